// File: doc/BRIEF.md
# System Table Register Loader

This block runs the load of either the local-table register or the task register from a 16-bit selector. The caller supplies the selector, the current privilege level, two mode flags and the base and limit of the global descriptor table, then pulses `start`. The sequencer checks the selector against privilege and table bounds. It fetches the two 32-bit halves of the referenced descriptor over a request/acknowledge memory port and validates the descriptor's class, type and presence. On success it updates the chosen selector register together with its cached 64-bit descriptor and valid flag.

A task-register load also marks the task descriptor busy in memory: bit 9 of the high dword is set and that dword is written back. Any failure ends the operation with one fault kind and a 16-bit error code, and leaves every register unchanged. A descriptor whose effective limit is smaller than the minimum for its kind loads normally, but `limit_warn` is raised.

Top module: `sysreg_loader`

## Requirements
- R1: With `prot_en` low or `v86_en` high, the operation ends with fault kind 3 (undefined operation), error code 0 and no memory transfer. Fault kinds: 0 none, 1 general protection, 2 not present, 3 undefined operation.
- R2: With `cpl` not 0, the operation ends with fault kind 1, error code 0 and no memory transfer.
- R3: A selector with bits [15:2] all zero has two outcomes. For a local-table load it writes the selector into `ldt_sel`, clears `ldt_valid`, keeps `ldt_desc` and ends with no fault and no memory transfer. For a task load it ends with fault kind 1, code 0 and no transfer.
- R4: A selector with bit 2 (table indicator) set ends with fault kind 1 and error code equal to the selector with bits [1:0] cleared, with no transfer.
- R5: When {selector[15:3], 3'b111} exceeds `gdt_limit`, the operation ends with fault kind 1 and the selector-derived code, with no transfer. Equality is accepted.
- R6: The low descriptor dword is read from `gdt_base` + index×8 and then the high dword from `gdt_base` + index×8 + 4, where index is selector[15:3].
- R7: The high dword must have bit 12 clear, and its type field [11:8] must be 2 for a local-table load or 1 or 9 for a task load. Any other descriptor gives fault kind 1 with the selector-derived code.
- R8: A descriptor that passes R7 but has bit 15 (present) clear gives fault kind 2 with the selector-derived code.
- R9: Exactly one fault is reported per operation. Checks are taken in the order mode, privilege, null, table indicator, limit, type, present.
- R10: A faulting operation changes none of `ldt_sel`, `ldt_valid`, `ldt_desc`, `tr_sel`, `tr_valid`, `tr_desc`.
- R11: A successful local-table load sets `ldt_sel` to the selector, `ldt_desc` to {high, low} as read and `ldt_valid` to 1, and writes no memory.
- R12: A successful task load writes the high dword with bit 9 set to `gdt_base` + index×8 + 4. When that write is acknowledged it sets `tr_sel`, `tr_desc` ({high, low} as read) and `tr_valid`.
- R13: On success, `limit_warn` is 1 when the effective limit is below 7 for a local table, below 43 for type 1 or below 103 for type 9. The effective limit is {high[19:16], low[15:0]}, shifted left by 12 with 0xFFF filled in when high bit 23 is set. `limit_warn` is 0 on a fault.
- R14: `mem_req` stays high with stable `mem_addr` and `mem_we` until `mem_ack` is seen. `done` pulses for one cycle at the end of each operation, and `fault_kind`, `fault_code` and `limit_warn` hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| load_task | input | 1 | 1 loads the task register, 0 the local-table register |
| sel | input | SEL_W | Selector to load |
| cpl | input | 2 | Current privilege level |
| prot_en | input | 1 | Protected mode active |
| v86_en | input | 1 | Virtual-8086 mode active |
| gdt_base | input | AW | Global table base address |
| gdt_limit | input | SEL_W | Global table limit |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | AW | Transfer byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer complete |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| fault_kind | output | 2 | Fault kind of the last operation |
| fault_code | output | 16 | Error code of the last operation |
| limit_warn | output | 1 | Loaded descriptor limit below minimum |
| ldt_sel | output | SEL_W | Local-table selector register |
| ldt_valid | output | 1 | Local-table cache valid |
| ldt_desc | output | 64 | Cached local-table descriptor |
| tr_sel | output | SEL_W | Task selector register |
| tr_valid | output | 1 | Task cache valid |
| tr_desc | output | 64 | Cached task descriptor |

## Verification
The bench targets the places where check order and the busy write-back are easy to get wrong. A CPL fault combined with a set table indicator must report code 0, not the selector. A bad type on a non-present descriptor must report general protection, not not-present. Both targets are swept over all sixteen types with every combination of class, present and granularity bits, across limits on either side of each warning threshold. A design that marked a local table busy, or wrote a failed task descriptor, shows up as a changed memory dword. A design that loaded a register on a fault shows up as a register mismatch. The limit comparison is probed at exact equality and one byte short, which catches an off-by-one.

// File: rtl/sysreg_ld_pkg.sv
package sysreg_ld_pkg;
  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_GP   = 2'd1,
    FK_NP   = 2'd2,
    FK_UD   = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_RD_LO,
    S_RD_HI,
    S_VALIDATE,
    S_WR_HI
  } state_e;

  localparam logic [3:0] TYPE_LDT   = 4'd2;
  localparam logic [3:0] TYPE_TSS16 = 4'd1;
  localparam logic [3:0] TYPE_TSS32 = 4'd9;

  localparam logic [31:0] MIN_LIM_LDT   = 32'd7;
  localparam logic [31:0] MIN_LIM_TSS16 = 32'd43;
  localparam logic [31:0] MIN_LIM_TSS32 = 32'd103;

  localparam int BUSY_BIT    = 9;
  localparam int CLASS_BIT   = 12;
  localparam int PRESENT_BIT = 15;
  localparam int GRAN_BIT    = 23;
endpackage

// File: rtl/sysreg_ld_precheck.sv
module sysreg_ld_precheck
  import sysreg_ld_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic             to_task,
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       cpl,
  input  logic             prot_en,
  input  logic             v86_en,
  input  logic [SEL_W-1:0] gdt_limit,
  output fault_e           kind,
  output logic [SEL_W-1:0] code,
  output logic             null_ldt
);
  logic [SEL_W-1:0] sel_code;
  logic [SEL_W-1:0] last_byte;
  logic             is_null;

  assign sel_code  = {sel[SEL_W-1:2], 2'b00};
  assign last_byte = {sel[SEL_W-1:3], 3'b111};
  assign is_null   = (sel[SEL_W-1:2] == '0);

  always_comb begin
    kind     = FK_NONE;
    code     = '0;
    null_ldt = 1'b0;
    if (!prot_en || v86_en) begin
      kind = FK_UD;
    end else if (cpl != 2'd0) begin
      kind = FK_GP;
    end else if (is_null) begin
      if (to_task) kind = FK_GP;
      else         null_ldt = 1'b1;
    end else if (sel[2]) begin
      kind = FK_GP;
      code = sel_code;
    end else if (last_byte > gdt_limit) begin
      kind = FK_GP;
      code = sel_code;
    end
  end
endmodule

// File: rtl/sysreg_ld_desc_check.sv
module sysreg_ld_desc_check
  import sysreg_ld_pkg::*;
(
  input  logic        to_task,
  input  logic [31:0] lo,
  input  logic [31:0] hi,
  output fault_e      kind,
  output logic        warn
);
  logic [3:0]  typ;
  logic [19:0] raw_lim;
  logic [31:0] eff_lim;
  logic        type_ok;

  assign typ     = hi[11:8];
  assign raw_lim = {hi[19:16], lo[15:0]};
  assign eff_lim = hi[GRAN_BIT] ? {raw_lim, 12'hFFF} : {12'h000, raw_lim};

  always_comb begin
    if (to_task) type_ok = (typ == TYPE_TSS16) || (typ == TYPE_TSS32);
    else         type_ok = (typ == TYPE_LDT);
    type_ok = type_ok && !hi[CLASS_BIT];
  end

  always_comb begin
    if (!type_ok)              kind = FK_GP;
    else if (!hi[PRESENT_BIT]) kind = FK_NP;
    else                       kind = FK_NONE;
  end

  always_comb begin
    if (!to_task)                warn = eff_lim < MIN_LIM_LDT;
    else if (typ == TYPE_TSS16)  warn = eff_lim < MIN_LIM_TSS16;
    else                         warn = eff_lim < MIN_LIM_TSS32;
  end
endmodule

// File: rtl/sysreg_loader.sv
module sysreg_loader
  import sysreg_ld_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             load_task,
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       cpl,
  input  logic             prot_en,
  input  logic             v86_en,
  input  logic [AW-1:0]    gdt_base,
  input  logic [SEL_W-1:0] gdt_limit,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             busy,
  output logic             done,
  output logic [1:0]       fault_kind,
  output logic [15:0]      fault_code,
  output logic             limit_warn,
  output logic [SEL_W-1:0] ldt_sel,
  output logic             ldt_valid,
  output logic [63:0]      ldt_desc,
  output logic [SEL_W-1:0] tr_sel,
  output logic             tr_valid,
  output logic [63:0]      tr_desc
);
  localparam int PAD_W = AW - SEL_W;

  state_e           state_q;
  logic             task_q;
  logic [SEL_W-1:0] sel_q;
  logic [1:0]       cpl_q;
  logic             prot_q;
  logic             v86_q;
  logic [AW-1:0]    base_q;
  logic [SEL_W-1:0] lim_q;
  logic [31:0]      lo_q;
  logic [31:0]      hi_q;

  fault_e           pre_kind;
  logic [SEL_W-1:0] pre_code;
  logic             pre_null;
  fault_e           dsc_kind;
  logic             dsc_warn;
  logic [SEL_W-1:0] sel_code;
  logic [AW-1:0]    desc_addr;

  assign sel_code  = {sel_q[SEL_W-1:2], 2'b00};
  assign desc_addr = base_q + {{PAD_W{1'b0}}, sel_q[SEL_W-1:3], 3'b000};
  assign busy      = (state_q != S_IDLE);

  sysreg_ld_precheck #(.SEL_W(SEL_W)) u_pre (
    .to_task  (task_q),
    .sel      (sel_q),
    .cpl      (cpl_q),
    .prot_en  (prot_q),
    .v86_en   (v86_q),
    .gdt_limit(lim_q),
    .kind     (pre_kind),
    .code     (pre_code),
    .null_ldt (pre_null)
  );

  sysreg_ld_desc_check u_dsc (
    .to_task(task_q),
    .lo     (lo_q),
    .hi     (hi_q),
    .kind   (dsc_kind),
    .warn   (dsc_warn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      task_q     <= 1'b0;
      sel_q      <= '0;
      cpl_q      <= '0;
      prot_q     <= 1'b0;
      v86_q      <= 1'b0;
      base_q     <= '0;
      lim_q      <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      done       <= 1'b0;
      fault_kind <= FK_NONE;
      fault_code <= '0;
      limit_warn <= 1'b0;
      ldt_sel    <= '0;
      ldt_valid  <= 1'b0;
      ldt_desc   <= '0;
      tr_sel     <= '0;
      tr_valid   <= 1'b0;
      tr_desc    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            task_q     <= load_task;
            sel_q      <= sel;
            cpl_q      <= cpl;
            prot_q     <= prot_en;
            v86_q      <= v86_en;
            base_q     <= gdt_base;
            lim_q      <= gdt_limit;
            fault_kind <= FK_NONE;
            fault_code <= '0;
            limit_warn <= 1'b0;
            state_q    <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (pre_kind != FK_NONE) begin
            fault_kind <= pre_kind;
            fault_code <= 16'(pre_code);
            done       <= 1'b1;
            state_q    <= S_IDLE;
          end else if (pre_null) begin
            ldt_sel   <= sel_q;
            ldt_valid <= 1'b0;
            done      <= 1'b1;
            state_q   <= S_IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= desc_addr;
            state_q  <= S_RD_LO;
          end
        end
        S_RD_LO: begin
          if (mem_ack) begin
            lo_q     <= mem_rdata;
            mem_addr <= mem_addr + AW'(4);
            state_q  <= S_RD_HI;
          end
        end
        S_RD_HI: begin
          if (mem_ack) begin
            hi_q    <= mem_rdata;
            mem_req <= 1'b0;
            state_q <= S_VALIDATE;
          end
        end
        S_VALIDATE: begin
          if (dsc_kind != FK_NONE) begin
            fault_kind <= dsc_kind;
            fault_code <= 16'(sel_code);
            done       <= 1'b1;
            state_q    <= S_IDLE;
          end else if (!task_q) begin
            ldt_sel    <= sel_q;
            ldt_desc   <= {hi_q, lo_q};
            ldt_valid  <= 1'b1;
            limit_warn <= dsc_warn;
            done       <= 1'b1;
            state_q    <= S_IDLE;
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_wdata <= hi_q | (32'd1 << BUSY_BIT);
            state_q   <= S_WR_HI;
          end
        end
        S_WR_HI: begin
          if (mem_ack) begin
            mem_req    <= 1'b0;
            mem_we     <= 1'b0;
            tr_sel     <= sel_q;
            tr_desc    <= {hi_q, lo_q};
            tr_valid   <= 1'b1;
            limit_warn <= dsc_warn;
            done       <= 1'b1;
            state_q    <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R14
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R10
  fault_no_update_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fault_kind != FK_NONE) |->
      ($stable(ldt_sel) && $stable(ldt_valid) && $stable(tr_sel) && $stable(tr_valid)));

  // R2
  early_fault_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_CHECK && cpl_q != 2'd0) |=> (!mem_req && done && fault_kind != FK_NONE));

  // R12
  busy_bit_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_wdata[BUSY_BIT] && task_q));

  // R9
  single_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !(limit_warn && fault_kind != FK_NONE)));
endmodule

// File: tb/sysreg_loader_tb.sv
module sysreg_loader_tb;
  localparam int AW = 32;
  localparam logic [31:0] GBASE = 32'h20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        load_task = 1'b0;
  logic [15:0] sel = '0;
  logic [1:0]  cpl = '0;
  logic        prot_en = 1'b1;
  logic        v86_en = 1'b0;
  logic [31:0] gdt_base = GBASE;
  logic [15:0] gdt_limit = 16'h9F;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        busy, done, limit_warn;
  logic [1:0]  fault_kind;
  logic [15:0] fault_code;
  logic [15:0] ldt_sel, tr_sel;
  logic        ldt_valid, tr_valid;
  logic [63:0] ldt_desc, tr_desc;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [0:63];
  int          acc_cnt;
  logic [31:0] acc_addr [0:3];
  logic        acc_we [0:3];

  logic [15:0] m_ldt_sel = '0, m_tr_sel = '0;
  logic        m_ldt_valid = 1'b0, m_tr_valid = 1'b0;
  logic [63:0] m_ldt_desc = '0, m_tr_desc = '0;

  always #5 clk = ~clk;

  sysreg_loader #(.AW(AW), .SEL_W(16)) u_dut (
    .clk(clk), .rst(rst), .start(start), .load_task(load_task), .sel(sel),
    .cpl(cpl), .prot_en(prot_en), .v86_en(v86_en), .gdt_base(gdt_base),
    .gdt_limit(gdt_limit), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .fault_kind(fault_kind),
    .fault_code(fault_code), .limit_warn(limit_warn), .ldt_sel(ldt_sel),
    .ldt_valid(ldt_valid), .ldt_desc(ldt_desc), .tr_sel(tr_sel),
    .tr_valid(tr_valid), .tr_desc(tr_desc)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder: one transfer per two cycles
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (acc_cnt < 4) begin
          acc_addr[acc_cnt] = mem_addr;
          acc_we[acc_cnt]   = mem_we;
        end
        acc_cnt++;
        if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
        else        mem_rdata = mem[mem_addr[7:2]];
        mem_ack = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R14 watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic put_desc(input int idx, input logic [31:0] lo, input logic [31:0] hi);
    mem[(GBASE[7:0] >> 2) + idx*2]     = lo;
    mem[(GBASE[7:0] >> 2) + idx*2 + 1] = hi;
  endtask

  // expected outcome from the requirements
  task automatic model(input bit tgt, input logic [15:0] s, input logic [1:0] c,
                       input bit pe, input bit v8, input logic [31:0] lo,
                       input logic [31:0] hi, input logic [15:0] lim,
                       output logic [1:0] k, output logic [15:0] code,
                       output bit w, output bit nul, output int nacc);
    logic [3:0]  t;
    logic [31:0] eff;
    bit          tok;
    k = 2'd0; code = 16'h0; w = 1'b0; nul = 1'b0; nacc = 0;
    t = hi[11:8];
    eff = hi[23] ? {hi[19:16], lo[15:0], 12'hFFF} : {12'h0, hi[19:16], lo[15:0]};
    if (!pe || v8) k = 2'd3;
    else if (c != 0) k = 2'd1;
    else if (s[15:2] == 0) begin
      if (tgt) k = 2'd1; else nul = 1'b1;
    end else if (s[2]) begin k = 2'd1; code = s & 16'hFFFC; end
    else if ({s[15:3], 3'b111} > lim) begin k = 2'd1; code = s & 16'hFFFC; end
    else begin
      nacc = 2;
      tok = !hi[12] && (tgt ? (t == 4'd1 || t == 4'd9) : (t == 4'd2));
      if (!tok) begin k = 2'd1; code = s & 16'hFFFC; end
      else if (!hi[15]) begin k = 2'd2; code = s & 16'hFFFC; end
      else begin
        if (tgt) nacc = 3;
        if (!tgt) w = eff < 7;
        else if (t == 4'd1) w = eff < 43;
        else w = eff < 103;
      end
    end
  endtask

  task automatic run(input bit tgt, input logic [15:0] s, input logic [1:0] c,
                     input bit pe, input bit v8, input string tag);
    logic [1:0]  k;
    logic [15:0] code;
    bit          w, nul;
    int          nacc, idx, cyc;
    logic [31:0] lo, hi, eaddr;
    idx = int'(s[15:3]);
    lo = (idx < 24) ? mem[(GBASE[7:0] >> 2) + idx*2] : 32'h0;
    hi = (idx < 24) ? mem[(GBASE[7:0] >> 2) + idx*2 + 1] : 32'h0;
    eaddr = GBASE + idx*8;
    model(tgt, s, c, pe, v8, lo, hi, gdt_limit, k, code, w, nul, nacc);
    @(negedge clk);
    acc_cnt = 0;
    load_task = tgt; sel = s; cpl = c; prot_en = pe; v86_en = v8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    chk(done, "R14", {tag, " done seen"}, 64'(done), 64'd1);
    chk(fault_kind == k, (k == 3) ? "R1" : (k == 2) ? "R8" : "R9",
        {tag, " fault kind"}, 64'(fault_kind), 64'(k));
    chk(fault_code == code, "R4", {tag, " fault code"}, 64'(fault_code), 64'(code));
    chk(limit_warn == w, "R13", {tag, " limit warn"}, 64'(limit_warn), 64'(w));
    chk(acc_cnt == nacc, "R2", {tag, " transfer count"}, 64'(acc_cnt), 64'(nacc));
    if (nacc >= 2) begin
      chk(acc_addr[0] == eaddr && !acc_we[0], "R6", {tag, " low read addr"},
          64'(acc_addr[0]), 64'(eaddr));
      chk(acc_addr[1] == eaddr + 4 && !acc_we[1], "R6", {tag, " high read addr"},
          64'(acc_addr[1]), 64'(eaddr + 4));
    end
    if (nacc == 3)
      chk(acc_addr[2] == eaddr + 4 && acc_we[2], "R12", {tag, " busy write addr"},
          64'(acc_addr[2]), 64'(eaddr + 4));
    if (idx < 24) begin
      logic [31:0] ehi;
      ehi = (nacc == 3) ? (hi | 32'h200) : hi;
      chk(mem[(GBASE[7:0] >> 2) + idx*2 + 1] == ehi, "R12", {tag, " memory high dword"},
          64'(mem[(GBASE[7:0] >> 2) + idx*2 + 1]), 64'(ehi));
    end
    if (k == 2'd0) begin
      if (nul) begin m_ldt_sel = s; m_ldt_valid = 1'b0; end
      else if (tgt) begin m_tr_sel = s; m_tr_desc = {hi, lo}; m_tr_valid = 1'b1; end
      else begin m_ldt_sel = s; m_ldt_desc = {hi, lo}; m_ldt_valid = 1'b1; end
    end
    chk(ldt_sel == m_ldt_sel && ldt_valid == m_ldt_valid && ldt_desc == m_ldt_desc,
        (k != 0) ? "R10" : nul ? "R3" : "R11", {tag, " local-table regs"},
        {ldt_desc[47:0], ldt_valid, ldt_sel[14:0]}, {m_ldt_desc[47:0], m_ldt_valid, m_ldt_sel[14:0]});
    chk(tr_sel == m_tr_sel && tr_valid == m_tr_valid && tr_desc == m_tr_desc,
        (k != 0) ? "R10" : "R12", {tag, " task regs"},
        {tr_desc[47:0], tr_valid, tr_sel[14:0]}, {m_tr_desc[47:0], m_tr_valid, m_tr_sel[14:0]});
    prot_en = 1'b1; v86_en = 1'b0; cpl = 2'd0;
  endtask

  function automatic logic [31:0] mk_hi(input logic [3:0] t, input bit s, input bit p,
                                        input bit g, input logic [7:0] mid);
    return {8'h00, g, 3'b000, 4'h0, p, 2'b00, s, t, mid};
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    acc_cnt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_req && !ldt_valid && !tr_valid && ldt_sel == 0 && tr_sel == 0,
        "R14", "reset state", {busy, done, mem_req, ldt_valid, tr_valid}, 64'd0);

    // a good local-table descriptor at index 3, a good task one at index 4
    put_desc(3, 32'h1234_0040, mk_hi(4'd2, 1'b0, 1'b1, 1'b0, 8'h56));
    put_desc(4, 32'h0000_0068, mk_hi(4'd9, 1'b0, 1'b1, 1'b0, 8'h00));

    run(1'b0, 16'h0018, 2'd0, 1'b0, 1'b0, "R1 real mode");
    run(1'b1, 16'h0020, 2'd0, 1'b1, 1'b1, "R1 v86 mode");
    for (int c = 1; c < 4; c++) run(1'b0, 16'h0018, 2'(c), 1'b1, 1'b0, "R2 cpl");
    run(1'b1, 16'h001C, 2'd3, 1'b1, 1'b0, "R9 cpl before TI");
    run(1'b0, 16'h0018, 2'd0, 1'b1, 1'b0, "R11 good ldt");
    run(1'b0, 16'h0002, 2'd0, 1'b1, 1'b0, "R3 null ldt");
    run(1'b1, 16'h0001, 2'd0, 1'b1, 1'b0, "R3 null task");
    run(1'b0, 16'h001F, 2'd0, 1'b1, 1'b0, "R4 TI set");
    run(1'b0, 16'h00A7, 2'd0, 1'b1, 1'b0, "R9 TI before limit");
    run(1'b1, 16'h0020, 2'd0, 1'b1, 1'b0, "R12 good task");
    put_desc(19, 32'h0000_0010, mk_hi(4'd2, 1'b0, 1'b1, 1'b0, 8'h00));
    run(1'b0, 16'h0098, 2'd0, 1'b1, 1'b0, "R5 limit equal");
    run(1'b0, 16'h00A0, 2'd0, 1'b1, 1'b0, "R5 past limit");
    gdt_limit = 16'h9E;
    run(1'b0, 16'h0098, 2'd0, 1'b1, 1'b0, "R5 one short");
    gdt_limit = 16'h9F;
    put_desc(5, 32'h0000_0010, mk_hi(4'd5, 1'b0, 1'b0, 1'b0, 8'h00));
    run(1'b1, 16'h0028, 2'd0, 1'b1, 1'b0, "R9 type before present");

    // sweep over type, class, present, granularity and limit for both targets
    for (int tgt = 0; tgt < 2; tgt++) begin
      for (int code = 0; code < 128; code++) begin
        int idx;
        logic [15:0] lim_lo;
        idx = 1 + (code % 19);
        case (code % 7)
          0: lim_lo = 16'd6;
          1: lim_lo = 16'd7;
          2: lim_lo = 16'd42;
          3: lim_lo = 16'd43;
          4: lim_lo = 16'd102;
          5: lim_lo = 16'd103;
          default: lim_lo = 16'd0;
        endcase
        put_desc(idx, {16'(code * 3), lim_lo},
                 mk_hi(4'(code), code[4], code[5], code[6], 8'(code)));
        run(tgt[0], {13'(idx), 1'b0, 2'(code)}, 2'd0, 1'b1, 1'b0,
            tgt[0] ? "R7 task sweep" : "R7 ldt sweep");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule